// File: doc/BRIEF.md
# Gated Scaler Bank

A bank of general-purpose event counters that all advance on one shared increment strobe. Each channel counts only on strobes where its own gate condition is true. The gate is built from two pools of level inputs: a wide pool of 32 common control lines that every channel sees, and a small pool of 6 local control lines. Per-channel host registers choose which lines from each pool must be high. With an enable bit set and both masks empty, the gate is always open. After reset, local line i gates channel i.

Two neighbouring channels can be joined so that the odd channel becomes the upper half of one double-width counter. One host-selected channel's count is driven without pause onto a registered live output bus for downstream logic. A rising edge on the load-monitor input copies every count into snapshot registers. The host reads these through a channel-indexed read port. A clear register zeroes any chosen set of channels in one cycle.

Top module: `gated_scaler_bank`

## Requirements
- R1: While reset is low, every count, every snapshot and the live bus go to zero. Reset also sets the configuration: channel i (i < 6) is enabled with local mask 1<<i and common mask zero, channels from 6 upward are disabled, no pair is joined, and the live selection is channel 0.
- R2: With the configuration left at its reset values, channel i counts each strobe on which loc_in[i] is high and ignores strobes on which it is low.
- R3: A channel's gate is open when all of these hold: its enable bit is 1, every com_in bit set in its common mask is 1, and every loc_in bit set in its local mask is 1. Input bits outside the masks have no effect. With enable 1 and both masks zero, the channel counts every strobe.
- R4: A local mask with several bits set, for example 6'b110000, lets the channel count only when all of those local lines are high together.
- R5: A channel whose enable bit is 0 never counts, whatever its inputs are.
- R6: Counts change only on cycles where inc_strobe or clr_we is high. Level changes on com_in or loc_in without a strobe leave every count unchanged.
- R7: Each count wraps from all-ones to zero, modulo 2^CNT_W. When its pair is not joined, the wrap of an even channel has no effect on the odd channel above it.
- R8: A configuration write to even channel 2k with cfg_join = 1 joins the pair. Channel 2k+1 then increments exactly when channel 2k counts a strobe while holding all-ones, and the gate of channel 2k+1 is ignored.
- R9: live_out shows the count of the channel held in the selection register, one cycle after that count changes. A selection index of NUM_CH or more gives zero.
- R10: On the cycle after load_mon rises, every snapshot holds the counts from that edge. Holding load_mon high captures nothing more. rd_data shows, without a clock, the snapshot of channel rd_ch.
- R11: clr_we with bit i of clr_mask set zeroes channel i on the next edge and overrides a count in that same cycle. Channels whose clr_mask bit is clear are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_strobe | input | 1 | Shared scaler increment strobe, one cycle per count |
| com_in | input | 32 | Common control levels, shared by all channels |
| loc_in | input | 6 | Local control levels |
| load_mon | input | 1 | Snapshot request; acts on its rising edge |
| cfg_we | input | 1 | Write strobe for one channel's configuration |
| cfg_ch | input | CH_W | Channel addressed by the configuration write |
| cfg_com_mask | input | 32 | Common-pool mask to write |
| cfg_loc_mask | input | 6 | Local-pool mask to write |
| cfg_enable | input | 1 | Enable bit to write |
| cfg_join | input | 1 | Join flag, stored when cfg_ch is even |
| sel_we | input | 1 | Write strobe for the live-output selection |
| sel_ch | input | CH_W | Channel to place on the live bus |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | NUM_CH | Channels to zero on a clear |
| rd_ch | input | CH_W | Snapshot channel to read |
| rd_data | output | CNT_W | Snapshot of channel rd_ch |
| live_out | output | CNT_W | Registered count of the selected channel |

## Verification
The gate logic is driven with several patterns. Exact common-mask matches and all-ones common words show that unmasked bits are ignored. Common words with one masked bit missing, and a low local line, show that any single missing term blocks the count. Single and paired local lines tell a one-line local mask apart from a two-line AND. A disabled channel with open inputs tells the enable term from the masks. The bench uses an 8-bit counter width so that a run of 260 strobes reaches the wrap, first with the pair split and then with it joined, while the odd channel's own gate is held open. This shows that its count comes only from the carry.

// File: rtl/gsb_pkg.sv
// Shared definitions for the gated scaler bank.
// Assumes: the pool widths are fixed for the whole bank.
package gsb_pkg;
    localparam int COM_W = 32;   // common control pool
    localparam int LOC_W = 6;    // local control pool

    // Per-channel gate configuration
    typedef struct packed {
        logic             en;
        logic [LOC_W-1:0] loc_mask;
        logic [COM_W-1:0] com_mask;
    } chan_cfg_t;
endpackage

// File: rtl/gsb_cfg.sv
// Host configuration registers: per-channel gate setup, the pair-join flags
// and the live-output selection.
// Assumes: one write per strobe; a join flag is stored only on a write to an
// even channel and applies to that channel and the next one.
module gsb_cfg
    import gsb_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CH_W   = 3,
    parameter int PAIR_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CH_W-1:0]  cfg_ch,
    input  logic [COM_W-1:0] cfg_com_mask,
    input  logic [LOC_W-1:0] cfg_loc_mask,
    input  logic             cfg_enable,
    input  logic             cfg_join,
    input  logic             sel_we,
    input  logic [CH_W-1:0]  sel_ch,
    output chan_cfg_t        cfg_q [NUM_CH],
    output logic [PAIR_N-1:0] join_q,
    output logic [CH_W-1:0]  sel_q
);

    // Channel gate registers: reset gives each local line its own channel
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n) begin
                cfg_q[i].en       <= (i < LOC_W);
                cfg_q[i].com_mask <= '0;
                cfg_q[i].loc_mask <= (i < LOC_W) ? (LOC_W'(1) << i) : '0;
            end else if (cfg_we && cfg_ch == CH_W'(i)) begin
                cfg_q[i].en       <= cfg_enable;
                cfg_q[i].com_mask <= cfg_com_mask;
                cfg_q[i].loc_mask <= cfg_loc_mask;
            end
        end
    end

    // Join flags, written through the lower (even) channel of each pair
    always_ff @(posedge clk) begin
        for (int p = 0; p < PAIR_N; p++) begin
            if (!rst_n)
                join_q[p] <= 1'b0;
            else if (cfg_we && cfg_ch == CH_W'(2 * p))
                join_q[p] <= cfg_join;
        end
    end

    // Live-output channel selection
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_we)
            sel_q <= sel_ch;
    end

endmodule

// File: rtl/gsb_gate.sv
// Gate evaluation for one channel: enable AND all masked common bits AND all
// masked local bits. Empty masks impose no condition.
// Assumes: inputs are synchronous levels, not clocks.
module gsb_gate
    import gsb_pkg::*;
(
    input  chan_cfg_t        cfg,
    input  logic [COM_W-1:0] com_in,
    input  logic [LOC_W-1:0] loc_in,
    output logic             gate
);

    logic com_ok;
    logic loc_ok;

    // A masked bit that is low blocks the gate
    always_comb begin
        com_ok = ((com_in & cfg.com_mask) == cfg.com_mask);
        loc_ok = ((loc_in & cfg.loc_mask) == cfg.loc_mask);
        gate   = cfg.en & com_ok & loc_ok;
    end

endmodule

// File: rtl/gsb_counter.sv
// One scaler channel: synchronous clear wins over increment; wraps modulo
// 2^CNT_W. Flags all-ones so the next channel can take a carry.
// Assumes: inc is already qualified by strobe and gate.
module gsb_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // Carry-out condition for a joined upper half
    assign full = &cnt;

endmodule

// File: rtl/gsb_capture.sv
// Snapshot buffers taken on the rising edge of load_mon, the unclocked
// readout mux, and the registered live output of the selected channel.
// Assumes: load_mon is synchronous to clk; out-of-range indices read zero.
module gsb_capture #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int CH_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_mon,
    input  logic [NUM_CH*CNT_W-1:0] cnt_flat,
    input  logic [CH_W-1:0]         sel_q,
    input  logic [CH_W-1:0]         rd_ch,
    output logic [CNT_W-1:0]        rd_data,
    output logic [CNT_W-1:0]        live_out,
    output logic [NUM_CH*CNT_W-1:0] snap_flat
);

    logic [CNT_W-1:0] cnt_arr  [NUM_CH];
    logic [CNT_W-1:0] snap_arr [NUM_CH];
    logic             load_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_unpack
        assign cnt_arr[i] = cnt_flat[i*CNT_W +: CNT_W];
        assign snap_flat[i*CNT_W +: CNT_W] = snap_arr[i];
    end

    // Previous load_mon level for edge detection (tracks through reset)
    always_ff @(posedge clk) begin
        load_q <= load_mon;
    end

    // Snapshot all channels on a rising load_mon
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n)
                snap_arr[i] <= '0;
            else if (load_mon && !load_q)
                snap_arr[i] <= cnt_arr[i];
        end
    end

    // Live bus: selected count, one register behind
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_out <= '0;
        else
            live_out <= (int'(sel_q) < NUM_CH) ? cnt_arr[sel_q] : '0;
    end

    // Host readout of the snapshot
    always_comb begin
        rd_data = (int'(rd_ch) < NUM_CH) ? snap_arr[rd_ch] : '0;
    end

endmodule

// File: rtl/gated_scaler_bank.sv
// Bank of gated scalers sharing one increment strobe. Each channel's gate is
// a masked AND over the common and local pools; odd channels can serve as the
// upper half of their even neighbour.
// Assumes: NUM_CH >= 2; all inputs synchronous to clk.
module gated_scaler_bank
    import gsb_pkg::*;
#(
    parameter  int NUM_CH = 6,
    parameter  int CNT_W  = 32,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc_strobe,
    input  logic [COM_W-1:0]   com_in,
    input  logic [LOC_W-1:0]   loc_in,
    input  logic               load_mon,
    input  logic               cfg_we,
    input  logic [CH_W-1:0]    cfg_ch,
    input  logic [COM_W-1:0]   cfg_com_mask,
    input  logic [LOC_W-1:0]   cfg_loc_mask,
    input  logic               cfg_enable,
    input  logic               cfg_join,
    input  logic               sel_we,
    input  logic [CH_W-1:0]    sel_ch,
    input  logic               clr_we,
    input  logic [NUM_CH-1:0]  clr_mask,
    input  logic [CH_W-1:0]    rd_ch,
    output logic [CNT_W-1:0]   rd_data,
    output logic [CNT_W-1:0]   live_out
);

    localparam int PAIR_N = (NUM_CH >= 2) ? NUM_CH / 2 : 1;

    chan_cfg_t               cfg_q [NUM_CH];
    logic [PAIR_N-1:0]       join_q;
    logic [CH_W-1:0]         sel_q;
    logic [NUM_CH-1:0]       gate;
    logic [NUM_CH-1:0]       inc_en;
    logic [NUM_CH-1:0]       full;
    logic [CNT_W-1:0]        cnt [NUM_CH];
    logic [NUM_CH*CNT_W-1:0] cnt_flat;
    logic [NUM_CH*CNT_W-1:0] snap_flat;

    gsb_cfg #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .PAIR_N (PAIR_N)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_ch       (cfg_ch),
        .cfg_com_mask (cfg_com_mask),
        .cfg_loc_mask (cfg_loc_mask),
        .cfg_enable   (cfg_enable),
        .cfg_join     (cfg_join),
        .sel_we       (sel_we),
        .sel_ch       (sel_ch),
        .cfg_q        (cfg_q),
        .join_q       (join_q),
        .sel_q        (sel_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        gsb_gate u_gate (
            .cfg    (cfg_q[i]),
            .com_in (com_in),
            .loc_in (loc_in),
            .gate   (gate[i])
        );

        // Odd channels take the neighbour's carry when joined
        if (i % 2 == 1) begin : g_upper
            assign inc_en[i] = inc_strobe &
                (join_q[i/2] ? (gate[i-1] & full[i-1]) : gate[i]);
        end else begin : g_lower
            assign inc_en[i] = inc_strobe & gate[i];
        end

        gsb_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_we & clr_mask[i]),
            .inc   (inc_en[i]),
            .cnt   (cnt[i]),
            .full  (full[i])
        );

        assign cnt_flat[i*CNT_W +: CNT_W] = cnt[i];
    end

    gsb_capture #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .CH_W   (CH_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_mon  (load_mon),
        .cnt_flat  (cnt_flat),
        .sel_q     (sel_q),
        .rd_ch     (rd_ch),
        .rd_data   (rd_data),
        .live_out  (live_out),
        .snap_flat (snap_flat)
    );

endmodule

// File: rtl/gsb_checker.sv
// Property checks for the gated scaler bank, bound into every instance.
// Assumes: observes counts and snapshots through the top's internal vectors.
module gsb_checker #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    inc_strobe,
    input logic                    clr_we,
    input logic [NUM_CH-1:0]       clr_mask,
    input logic                    load_mon,
    input logic [NUM_CH*CNT_W-1:0] cnt_flat,
    input logic [NUM_CH*CNT_W-1:0] snap_flat,
    input logic [CNT_W-1:0]        live_out
);

    // R1: reset zeroes counts, snapshots and the live bus
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (cnt_flat == '0 && snap_flat == '0 && live_out == '0));

    // R6: no strobe and no clear leaves every count unchanged
    a_r6_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_strobe && !clr_we) |=> $stable(cnt_flat));

    // R10: without a load_mon transition the snapshots hold
    a_r10_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(load_mon) |=> $stable(snap_flat));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R11: a selected clear zeroes the channel
        a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[i]) |=> (cnt_flat[i*CNT_W +: CNT_W] == '0));

        // R7: a count only holds, steps by one, or returns to zero
        a_r7_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ($stable(cnt_flat[i*CNT_W +: CNT_W]) ||
                      cnt_flat[i*CNT_W +: CNT_W] == '0 ||
                      cnt_flat[i*CNT_W +: CNT_W] ==
                          CNT_W'($past(cnt_flat[i*CNT_W +: CNT_W]) + 1'b1)));
    end

endmodule

bind gated_scaler_bank gsb_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_gsb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_strobe (inc_strobe),
    .clr_we     (clr_we),
    .clr_mask   (clr_mask),
    .load_mon   (load_mon),
    .cnt_flat   (cnt_flat),
    .snap_flat  (snap_flat),
    .live_out   (live_out)
);

// File: tb/gated_scaler_bank_test.sv
// Directed bench: one task per scenario, narrow counters to reach the wrap.
module gated_scaler_bank_test;
    localparam int NCH = 6;
    localparam int CW  = 8;
    localparam int CHW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           inc_strobe = 1'b0;
    logic [31:0]    com_in = '0;
    logic [5:0]     loc_in = '0;
    logic           load_mon = 1'b0;
    logic           cfg_we = 1'b0;
    logic [CHW-1:0] cfg_ch = '0;
    logic [31:0]    cfg_com_mask = '0;
    logic [5:0]     cfg_loc_mask = '0;
    logic           cfg_enable = 1'b0;
    logic           cfg_join = 1'b0;
    logic           sel_we = 1'b0;
    logic [CHW-1:0] sel_ch = '0;
    logic           clr_we = 1'b0;
    logic [NCH-1:0] clr_mask = '0;
    logic [CHW-1:0] rd_ch = '0;
    logic [CW-1:0]  rd_data;
    logic [CW-1:0]  live_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [CW-1:0] exp_cnt [NCH];

    always #2 clk = ~clk;

    gated_scaler_bank #(.NUM_CH(NCH), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .inc_strobe(inc_strobe), .com_in(com_in),
        .loc_in(loc_in), .load_mon(load_mon), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_com_mask(cfg_com_mask), .cfg_loc_mask(cfg_loc_mask),
        .cfg_enable(cfg_enable), .cfg_join(cfg_join), .sel_we(sel_we),
        .sel_ch(sel_ch), .clr_we(clr_we), .clr_mask(clr_mask), .rd_ch(rd_ch),
        .rd_data(rd_data), .live_out(live_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic snap_check(string req);
        @(negedge clk) load_mon = 1'b1;
        @(negedge clk) load_mon = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            rd_ch = CHW'(c);
            #1;
            chk($sformatf("%s ch%0d", req, c), 32'(rd_data), 32'(exp_cnt[c]));
        end
    endtask

    task automatic strobe(int n);
        @(negedge clk) inc_strobe = 1'b1;
        repeat (n) @(negedge clk);
        inc_strobe = 1'b0;
    endtask

    task automatic wr_cfg(int ch, logic [31:0] cm, logic [5:0] lm, logic en, logic j);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_com_mask = cm;
        cfg_loc_mask = lm; cfg_enable = en; cfg_join = j;
        @(negedge clk) cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk) begin clr_we = 1'b1; clr_mask = '1; end
        @(negedge clk) clr_we = 1'b0;
        for (int c = 0; c < NCH; c++) exp_cnt[c] = '0;
    endtask

    // R1: reset state of counts, snapshots and live bus
    task automatic t_reset();
        for (int c = 0; c < NCH; c++) exp_cnt[c] = '0;
        @(negedge clk);
        chk("R1 live_out", 32'(live_out), 0);
        snap_check("R1 snapshot");
    endtask

    // R2: default local gating per channel
    task automatic t_default();
        loc_in = 6'b000101;
        strobe(5);
        exp_cnt[0] = 5; exp_cnt[2] = 5;
        loc_in = '0;
        snap_check("R2 default gate");
    endtask

    // R6: level changes without a strobe do not count
    task automatic t_levels();
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            loc_in = 6'(k * 13);
            com_in = 32'hA5A5_0000 ^ 32'(k * 977);
        end
        loc_in = '0; com_in = '0;
        snap_check("R6 no strobe");
    endtask

    // R3: open gate and common-mask AND
    task automatic t_common();
        clear_all();
        wr_cfg(1, 32'h0, 6'h0, 1'b1, 1'b0);
        strobe(7);
        exp_cnt[1] = 7;
        snap_check("R3 open gate");
        wr_cfg(1, 32'h0, 6'b000010, 1'b1, 1'b0);
        clear_all();
        wr_cfg(3, 32'h00F0_0001, 6'b001000, 1'b1, 1'b0);
        loc_in = 6'b001000;
        com_in = 32'h00F0_0001; strobe(2);
        com_in = 32'hFFFF_FFFF; strobe(3);
        com_in = 32'h00E0_0001; strobe(4);
        com_in = 32'h00F0_0000; strobe(1);
        loc_in = '0; com_in = 32'hFFFF_FFFF; strobe(2);
        com_in = '0;
        exp_cnt[3] = 5;
        snap_check("R3 common mask");
    endtask

    // R4: two local lines ANDed
    task automatic t_local_pair();
        clear_all();
        wr_cfg(4, 32'h0, 6'b110000, 1'b1, 1'b0);
        loc_in = 6'b010000; strobe(3);
        loc_in = 6'b100000; strobe(2);
        loc_in = 6'b110000; strobe(4);
        loc_in = '0;
        exp_cnt[4] = 4; exp_cnt[5] = 6;
        snap_check("R4 local pair");
    endtask

    // R5: disabled channel never counts
    task automatic t_disable();
        clear_all();
        wr_cfg(5, 32'h0, 6'h0, 1'b0, 1'b0);
        loc_in = '1; com_in = '1;
        strobe(5);
        loc_in = '0; com_in = '0;
        for (int c = 0; c < 5; c++) exp_cnt[c] = 5;
        exp_cnt[5] = 0;
        snap_check("R5 disabled");
    endtask

    // R7 and R8: wrap alone, then joined pair with upper gate open
    task automatic t_wrap_join();
        clear_all();
        wr_cfg(0, 32'h0, 6'h0, 1'b1, 1'b0);
        strobe(260);
        exp_cnt[0] = 4; exp_cnt[1] = 0;
        snap_check("R7 wrap split");
        clear_all();
        wr_cfg(0, 32'h0, 6'h0, 1'b1, 1'b1);
        loc_in = 6'b000010;
        strobe(260);
        loc_in = '0;
        exp_cnt[0] = 4; exp_cnt[1] = 1;
        snap_check("R8 joined carry");
        wr_cfg(0, 32'h0, 6'h0, 1'b1, 1'b0);
    endtask

    // R9: live bus lag and out-of-range selection
    task automatic t_live();
        clear_all();
        @(negedge clk) begin sel_we = 1'b1; sel_ch = '0; end
        @(negedge clk) sel_we = 1'b0;
        @(negedge clk) inc_strobe = 1'b1;
        @(negedge clk) inc_strobe = 1'b0;
        chk("R9 live lags one cycle", 32'(live_out), 0);
        @(negedge clk);
        chk("R9 live follows", 32'(live_out), 1);
        exp_cnt[0] = 1;
        @(negedge clk) begin sel_we = 1'b1; sel_ch = 3'd7; end
        @(negedge clk) sel_we = 1'b0;
        @(negedge clk);
        chk("R9 live out of range", 32'(live_out), 0);
    endtask

    // R10: capture on rising edge only
    task automatic t_snapshot();
        @(negedge clk) load_mon = 1'b1;
        @(negedge clk);
        strobe(3);
        rd_ch = '0; #1;
        chk("R10 held high no recapture", 32'(rd_data), 1);
        @(negedge clk) load_mon = 1'b0;
        @(negedge clk) load_mon = 1'b1;
        @(negedge clk) load_mon = 1'b0;
        rd_ch = '0; #1;
        chk("R10 new edge captures", 32'(rd_data), 4);
        exp_cnt[0] = 4;
    endtask

    // R11: clear beats a same-cycle count, other channels keep counting
    task automatic t_clear();
        loc_in = 6'b000100;
        @(negedge clk) begin
            inc_strobe = 1'b1; clr_we = 1'b1; clr_mask = 6'b000001;
        end
        @(negedge clk) clr_we = 1'b0;
        @(negedge clk) inc_strobe = 1'b0;
        loc_in = '0;
        exp_cnt[0] = 1; exp_cnt[2] = 2;
        snap_check("R11 selective clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default();
        t_levels();
        t_common();
        t_local_pair();
        t_disable();
        t_wrap_join();
        t_live();
        t_snapshot();
        t_clear();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule